// File: doc/BRIEF.md
# Two-Phase Track Packet Receiver

This block listens to a shared, bit-serial track data line and turns the packets on it into controller records. While it is idle, a rising edge on the synchronised line arms it. A local timebase then produces one sampling tick every `TICK_CYCLES` clocks (50 us in the target system). Each bit slot uses two consecutive ticks. The data value is taken only in the second tick of the pair. A slot in which the line reads high on both ticks closes the frame. Packets therefore need neither a fixed length nor a stop bit.

When a frame closes, the receiver raises a one-cycle completion strobe. With it come the number of bits received and the most recent bits of the shift buffer. A frame of exactly 10 bits is a controller packet. For such a frame the block also raises a valid strobe with the car number, a 4-bit speed and a lane-change request flag. It writes the speed and the flag into an 8-entry table indexed by car number. A combinational lookup port reads any table entry. Frames that run past the bit-counter limit are abandoned without any report.

The receive sequencer has four states:
- `RX_IDLE`: waiting for an arming edge.
- `RX_PH2`: waiting for the second tick of a slot.
- `RX_PH1`: waiting for the first tick of the next slot.
- `RX_DONE`: the one-cycle report.

Its transitions are:
- **arm**: `RX_IDLE`→`RX_PH2`
- **shift**: `RX_PH2`→`RX_PH1`
- **close**: `RX_PH2`→`RX_DONE`
- **overrun**: `RX_PH2`→`RX_IDLE`
- **lead**: `RX_PH1`→`RX_PH2`
- **report**: `RX_DONE`→`RX_IDLE`

Top module: `trk_packet_rx`

## Requirements
- R1: While idle, the receiver arms only on a rising edge of the synchronised line. A line held high, or held low, never arms it.
- R2: After arming, the sampling tick repeats every TICK_CYCLES clocks, counted from the arming cycle. The ticks alternate between the second phase of a slot and the first phase of the next slot. The first slot after arming has only its second phase, because the arming edge stands in for its first phase.
- R3: On each second-phase tick that does not close the frame, the receiver shifts one bit into the low end of the buffer: a low line gives 1 and a high line gives 0. The bit count increases by one. `pkt_bits[0]` is therefore the last bit received, and older bits sit at higher positions.
- R4: When the line is high on both the first-phase and the second-phase tick of one slot, the frame closes. `pkt_done` then rises for exactly one cycle, with `pkt_len` equal to the number of bits shifted in and `pkt_bits` holding the buffer. Outside that cycle, `pkt_len` and `pkt_bits` read zero.
- R5: The first slot after arming can never close the frame. A high line in its second phase is received as a data 0.
- R6: A frame of exactly 10 bits raises `pkt_valid` together with `pkt_done`. In that cycle:
  - `car_id` is buffer bits [8:6].
  - `speed` is buffer bits [4:1].
  - `sw_req` is buffer bit 5.
  
  Otherwise `pkt_valid`, `car_id`, `speed` and `sw_req` read zero.
- R7: The car table holds 8 entries of speed and request flag. It is written only in a `pkt_valid` cycle, at the entry given by `car_id`. `rd_speed` and `rd_sw` show the entry selected by `rd_car` combinationally. Frames of any other length leave every entry unchanged.
- R8: The 6-bit bit count saturates at 63. A 63-bit frame is still reported. A 64th bit that does not close the frame returns the receiver to idle with no strobe.
- R9: Rising edges on the line while a frame is being received do not restart reception. After a frame closes, a new rising edge is needed to arm again.
- R10: After reset the receiver is idle, all strobes and outputs are zero, and every table entry reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Raw track data line (asynchronous) |
| pkt_done | output | 1 | One-cycle strobe when a frame closes |
| pkt_len | output | 6 | Bits received in the closed frame |
| pkt_bits | output | 16 | Last 16 received bits, newest in bit 0 |
| pkt_valid | output | 1 | Strobe for a decoded 10-bit controller packet |
| car_id | output | 3 | Decoded car number |
| speed | output | 4 | Decoded speed |
| sw_req | output | 1 | Decoded lane-change request |
| rd_car | input | 3 | Table lookup index |
| rd_speed | output | 4 | Speed stored for `rd_car` |
| rd_sw | output | 1 | Request flag stored for `rd_car` |

## Verification
Controller frames are sent with:
- mixed payloads;
- a first bit of 0, which puts a high line in the arming slot and separates R5 from a premature close;
- all ones;
- all zeros, whose low-to-high phase changes throw many rising edges at an active receiver.

Frames of 9 and 11 bits reuse the same car bits, so any table write on a non-controller length shows up as a changed entry. A 63-bit frame and a 64-bit unterminated run bracket the counter limit. A line left high after a frame closes would expose re-arming from a level instead of an edge.

// File: rtl/trk_rx_pkg.sv
package trk_rx_pkg;

    localparam int CAR_ID_W = 3;
    localparam int SPEED_W  = 4;
    localparam int NUM_CARS = 1 << CAR_ID_W;
    localparam int CTRL_LEN = 10;

    // field positions inside a controller frame (newest bit at 0)
    localparam int SPEED_LSB = 1;
    localparam int SW_POS    = 5;
    localparam int ID_LSB    = 6;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_PH2  = 2'd1,
        RX_PH1  = 2'd2,
        RX_DONE = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic [SPEED_W-1:0] speed;
        logic               sw_req;
    } car_entry_t;

endpackage

// File: rtl/trk_rx_sync_edge.sv
module trk_rx_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic rise
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= line_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[SYNC_STAGES-1];
    end

    assign line_s = chain_q[SYNC_STAGES-1];
    assign rise   = line_s & ~prev_q;

    // a rising edge is never reported on a line that was already high
    AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);  // R1

endmodule

// File: rtl/trk_rx_tick.sv
module trk_rx_tick #(
    parameter int TICK_CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && !clr && (cnt_q == LAST);

    // ticks are spaced, never back to back
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);  // R2

    AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);  // R2

endmodule

// File: rtl/trk_rx_frame_fsm.sv
module trk_rx_frame_fsm
    import trk_rx_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int BUF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_s,
    input  logic             rise,
    input  logic             tick,
    output logic             tick_run,
    output logic             tick_clr,
    output logic             pkt_done,
    output logic [CNT_W-1:0] pkt_len,
    output logic [BUF_W-1:0] pkt_bits
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] bit_cnt_q;
    logic [BUF_W-1:0] shreg_q;
    logic             first_high_q;

    logic arm;
    logic frame_end;
    logic saturated;

    assign arm       = (state_q == RX_IDLE) && rise;
    assign frame_end = first_high_q && line_s;
    assign saturated = (bit_cnt_q == CNT_MAX);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (rise) state_d = RX_PH2;
            RX_PH2: begin
                if (tick) begin
                    if (frame_end)      state_d = RX_DONE;
                    else if (saturated) state_d = RX_IDLE;
                    else                state_d = RX_PH1;
                end
            end
            RX_PH1:  if (tick) state_d = RX_PH2;
            RX_DONE: state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q    <= '0;
            shreg_q      <= '0;
            first_high_q <= 1'b0;
        end else if (arm) begin
            bit_cnt_q    <= '0;
            shreg_q      <= '0;
            first_high_q <= 1'b0;
        end else if (tick && state_q == RX_PH2 && !frame_end && !saturated) begin
            shreg_q   <= {shreg_q[BUF_W-2:0], ~line_s};
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end else if (tick && state_q == RX_PH1) begin
            first_high_q <= line_s;
        end
    end

    // outputs
    always_comb begin
        tick_run = (state_q == RX_PH2) || (state_q == RX_PH1);
        tick_clr = arm;
        pkt_done = (state_q == RX_DONE);
        pkt_len  = pkt_done ? bit_cnt_q : '0;
        pkt_bits = pkt_done ? shreg_q : '0;
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_IDLE && !rise) |=> state_q == RX_IDLE);  // R1

    AST_BIT_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_PH2 && tick && !frame_end && !saturated)
            |=> bit_cnt_q == $past(bit_cnt_q) + 1'b1);  // R3

    AST_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_PH2 && tick && first_high_q && line_s)
            |=> state_q == RX_DONE);  // R4

    AST_FIRST_SLOT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !first_high_q);  // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_PH2 && tick && !frame_end && saturated)
            |=> state_q == RX_IDLE);  // R8

    AST_EDGES_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == RX_PH2 || state_q == RX_PH1) && !tick)
            |=> $stable(state_q) && $stable(bit_cnt_q));  // R9

endmodule

// File: rtl/trk_car_table.sv
module trk_car_table
    import trk_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CAR_ID_W-1:0] wr_id,
    input  car_entry_t          wr_entry,
    input  logic [CAR_ID_W-1:0] rd_id,
    output car_entry_t          rd_entry
);
    car_entry_t [NUM_CARS-1:0] slot_q;

    generate
        for (genvar c = 0; c < NUM_CARS; c++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot_q[c] <= '0;
                end else if (wr_en && wr_id == CAR_ID_W'(c)) begin
                    slot_q[c] <= wr_entry;
                end
            end
        end
    endgenerate

    assign rd_entry = slot_q[rd_id];

    AST_TABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(slot_q));  // R7

endmodule

// File: rtl/trk_packet_rx.sv
module trk_packet_rx
    import trk_rx_pkg::*;
#(
    parameter int TICK_CYCLES = 2500,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 6,
    parameter int BUF_W       = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_in,
    output logic                pkt_done,
    output logic [CNT_W-1:0]    pkt_len,
    output logic [BUF_W-1:0]    pkt_bits,
    output logic                pkt_valid,
    output logic [CAR_ID_W-1:0] car_id,
    output logic [SPEED_W-1:0]  speed,
    output logic                sw_req,
    input  logic [CAR_ID_W-1:0] rd_car,
    output logic [SPEED_W-1:0]  rd_speed,
    output logic                rd_sw
);
    logic       line_s;
    logic       rise;
    logic       tick;
    logic       tick_run;
    logic       tick_clr;
    car_entry_t wr_entry;
    car_entry_t rd_entry;

    trk_rx_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(line_in),
        .line_s (line_s),
        .rise   (rise)
    );

    trk_rx_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (tick_run),
        .clr  (tick_clr),
        .tick (tick)
    );

    trk_rx_frame_fsm #(.CNT_W(CNT_W), .BUF_W(BUF_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_s  (line_s),
        .rise    (rise),
        .tick    (tick),
        .tick_run(tick_run),
        .tick_clr(tick_clr),
        .pkt_done(pkt_done),
        .pkt_len (pkt_len),
        .pkt_bits(pkt_bits)
    );

    // controller packet decode
    always_comb begin
        pkt_valid = pkt_done && (pkt_len == CNT_W'(CTRL_LEN));
        car_id    = '0;
        speed     = '0;
        sw_req    = 1'b0;
        if (pkt_valid) begin
            car_id = pkt_bits[ID_LSB +: CAR_ID_W];
            speed  = pkt_bits[SPEED_LSB +: SPEED_W];
            sw_req = pkt_bits[SW_POS];
        end
        wr_entry.speed  = speed;
        wr_entry.sw_req = sw_req;
    end

    trk_car_table u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pkt_valid),
        .wr_id   (car_id),
        .wr_entry(wr_entry),
        .rd_id   (rd_car),
        .rd_entry(rd_entry)
    );

    assign rd_speed = rd_entry.speed;
    assign rd_sw    = rd_entry.sw_req;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);  // R4

    AST_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> pkt_done);  // R6

endmodule

// File: tb/sim_trk_packet_rx.sv
module sim_trk_packet_rx;

    localparam int CLK_PERIOD = 10;
    localparam int P          = 4;

    typedef struct packed {
        logic [5:0]  len;
        logic        valid;
        logic [2:0]  id;
        logic [3:0]  spd;
        logic        sw;
        logic [15:0] bits;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_in = 1'b0;
    logic        pkt_done, pkt_valid, sw_req, rd_sw;
    logic [5:0]  pkt_len;
    logic [15:0] pkt_bits;
    logic [2:0]  car_id;
    logic [2:0]  rd_car = 3'd0;
    logic [3:0]  speed, rd_speed;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    exp_t q[$];
    logic [4:0] exp_tab [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    trk_packet_rx #(.TICK_CYCLES(P)) u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .pkt_done(pkt_done), .pkt_len(pkt_len), .pkt_bits(pkt_bits),
        .pkt_valid(pkt_valid), .car_id(car_id), .speed(speed), .sw_req(sw_req),
        .rd_car(rd_car), .rd_speed(rd_speed), .rd_sw(rd_sw)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: sends a frame MSB first and pushes the expected report
    task automatic send(input logic [63:0] v, input int n, input bit close, input bit hold_high);
        exp_t e;
        line_in = 1'b0;
        repeat (4) @(negedge clk);
        line_in = 1'b1;                              // arming edge
        repeat (P) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            line_in = ~v[n-1-i];                     // second phase carries data
            repeat (P) @(negedge clk);
            line_in = (i == n-1) && close;           // next first phase
            repeat (P) @(negedge clk);
        end
        if (close) begin
            e.len   = 6'(n);
            e.valid = (n == 10);
            e.id    = (n == 10) ? v[8:6] : 3'd0;
            e.spd   = (n == 10) ? v[4:1] : 4'd0;
            e.sw    = (n == 10) ? v[5]   : 1'b0;
            e.bits  = v[15:0];
            q.push_back(e);
            if (n == 10) exp_tab[v[8:6]] = {v[4:1], v[5]};
            line_in = 1'b1;                          // closing second phase
            repeat (P) @(negedge clk);
        end
        line_in = hold_high;
        repeat (hold_high ? 12*P : 3*P) @(negedge clk);
        line_in = 1'b0;
        repeat (2*P) @(negedge clk);
    endtask

    // monitor: compares each report against the head of the queue
    always @(negedge clk) begin
        if (rst_n && pkt_done) begin
            if (q.size() == 0) begin
                check("R1/R8 unexpected report", {58'd0, pkt_len}, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check("R4 pkt_len", {58'd0, pkt_len}, {58'd0, e.len});
                check("R3 pkt_bits", {48'd0, pkt_bits}, {48'd0, e.bits});
                check("R6 valid/id/speed/sw",
                      {51'd0, pkt_valid, car_id, speed, sw_req},
                      {51'd0, e.valid, e.id, e.spd, e.sw});
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && pkt_done) begin
            @(negedge clk);
            check("R4 single-cycle done", {63'd0, pkt_done}, 64'd0);
        end
    end

    task automatic table_check(input string req);
        for (int c = 0; c < 8; c++) begin
            rd_car = 3'(c);
            #1;
            check(req, {59'd0, rd_speed, rd_sw}, {59'd0, exp_tab[c]});
        end
    endtask

    initial begin
        for (int c = 0; c < 8; c++) exp_tab[c] = 5'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 reset strobes", {60'd0, pkt_done, pkt_valid, sw_req, 1'b0}, 64'd0);
        check("R10 reset fields", {51'd0, pkt_len, car_id, speed}, 64'd0);
        table_check("R10 reset table");

        // R1: held-low line produces nothing
        repeat (10*P) @(negedge clk);

        send(64'b1_101_1_0110_1, 10, 1, 0);          // R6 car 5
        send(64'b0_011_0_1111_0, 10, 1, 0);          // R5 first bit zero, car 3
        send(64'h3FF, 10, 1, 0);                     // car 7 all ones
        send(64'h000, 10, 1, 1);                     // R9 all zeros, then R1 held high
        send(64'b0_1_101_1_0011, 9, 1, 0);           // R7 9-bit, must not write
        send(64'b101_1_0011_01, 11, 1, 0);           // R7 11-bit, must not write
        send(64'h5A5A_C3C3_0F0F_1234 & 64'h7FFF_FFFF_FFFF_FFFF, 63, 1, 0); // R8 limit
        send(64'hAAAA_AAAA_AAAA_AAAA, 64, 0, 0);     // R8 overrun, no report
        send(64'b0_010_0_1001_0, 10, 1, 0);          // R8 recovery, car 2

        repeat (4*P) @(negedge clk);
        check("R8 queue drained", 64'(q.size()), 64'd0);
        table_check("R7 table contents");

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule